// File: doc/BRIEF.md
# Multi-Cycle Fetch and Memory Sequencer

This block is the control core of a 16-bit processor built around one shared bus. It owns the program counter, the memory address and memory data registers and the instruction register. It steps each instruction through fetch, decode and whatever memory phases the opcode needs. A synchronous single-port memory sits outside the block and has one cycle of read latency. An external address generator supplies the effective address. An external register file and ALU supply the ALU result and the store data, and they take the destination write from the bus when the load strobe is high. The register file takes the destination index from instruction bits 11:9.

Each state enables at most one source onto the bus: the PC, the data register, the ALU result, the effective address or the store data. Loads go memory → data register → bus → register file. Stores go register file → bus → data register → memory, so no word moves straight from memory to memory. The indirect forms make an extra read, and the word it returns becomes the address of the real access. Address computation with no memory access writes the effective address straight to the destination register. Opcodes outside the supported set raise a one-cycle flag and go back to fetch.

Top module: `fetch_mem_seq`

## Requirements
- R1: While reset is held, `pc` reads 16'h3000 and `mem_en`, `reg_ld` and `illegal` are low. After release the bus first carries 16'h3000, and the first memory access is a read of address 16'h3000.
- R2: Every instruction starts with exactly one memory read at the current PC. The word read is loaded into `ir`, and `pc` then advances by one.
- R3: Opcodes 4'b0001, 4'b0101 and 4'b1001 (`ir[15:12]`) make no memory access. They assert `reg_ld` for one cycle with `alu_in` on `bus_out`.
- R4: Opcodes 4'b0010 and 4'b0110 make one read at `ea_in`. The word returned one cycle after the enable is later put on `bus_out` with `reg_ld` high.
- R5: Opcode 4'b1010 reads a pointer at `ea_in`, then reads the data at that pointer, and loads the data word into the destination register.
- R6: Opcodes 4'b0011 and 4'b0111 write `src_in` to address `ea_in` with one write cycle. They do not assert `reg_ld`. The stored word passes through the data register first.
- R7: Opcode 4'b1011 reads a pointer at `ea_in`, then writes `src_in` to the address held in the pointer.
- R8: Opcode 4'b1110 puts `ea_in` on `bus_out` with `reg_ld` high and makes no memory access.
- R9: Any other opcode pulses `illegal` for one cycle. It asserts no `reg_ld` and no write, and the next fetch reads the already incremented PC.
- R10: At most one bus source is enabled per cycle. `bus_out` is zero when none is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | 1 = write, 0 = read (when enabled) |
| mem_addr | output | 16 | Memory address (address register) |
| mem_wdata | output | 16 | Write data (data register) |
| mem_rdata | input | 16 | Read data, valid one cycle after a read enable |
| ea_in | input | 16 | Effective address from the external generator |
| alu_in | input | 16 | ALU result for operate instructions |
| src_in | input | 16 | Source register value for stores |
| pc | output | 16 | Program counter |
| ir | output | 16 | Instruction register |
| bus_out | output | 16 | Shared bus value |
| reg_ld | output | 1 | Destination register load strobe |
| illegal | output | 1 | One-cycle unsupported-opcode flag |

## Verification
The bench runs a short program that covers every supported opcode. It includes positive and negative offsets, base-relative and PC-relative addressing, immediate and register ALU operands, and an unsupported opcode placed between two valid ones. It also stores a word and loads it back later, which shows that memory writes and later reads agree. A direct load and an indirect load of different words tell apart one read from two chained reads. The total count of reads and writes tells address-only computation from real memory traffic.

// File: rtl/fetch_mem_seq_pkg.sv
package fetch_mem_seq_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_ADD = 4'h1;
  localparam logic [OPC_W-1:0] OP_LD  = 4'h2;
  localparam logic [OPC_W-1:0] OP_ST  = 4'h3;
  localparam logic [OPC_W-1:0] OP_AND = 4'h5;
  localparam logic [OPC_W-1:0] OP_LDR = 4'h6;
  localparam logic [OPC_W-1:0] OP_STR = 4'h7;
  localparam logic [OPC_W-1:0] OP_NOT = 4'h9;
  localparam logic [OPC_W-1:0] OP_LDI = 4'hA;
  localparam logic [OPC_W-1:0] OP_STI = 4'hB;
  localparam logic [OPC_W-1:0] OP_LEA = 4'hE;

  // bus source indices
  localparam int NDRV    = 5;
  localparam int DRV_PC  = 0;
  localparam int DRV_MDR = 1;
  localparam int DRV_ALU = 2;
  localparam int DRV_EA  = 3;
  localparam int DRV_SRC = 4;

  typedef enum logic [4:0] {
    S_F_MAR, S_F_RD, S_F_CAP, S_F_IR, S_DEC,
    S_EXE, S_LEA, S_EA_MAR,
    S_P_RD, S_P_CAP, S_P_MAR,
    S_D_RD, S_D_CAP, S_WB,
    S_S_DATA, S_S_WR, S_ILL
  } seq_state_t;

  typedef struct packed {
    logic [NDRV-1:0] drive;
    logic mar_ld;
    logic mdr_cap;
    logic mdr_ld_bus;
    logic ir_ld;
    logic pc_inc;
    logic mem_en;
    logic mem_we;
    logic reg_ld;
    logic illegal;
  } seq_ctl_t;

endpackage

// File: rtl/fetch_mem_seq_ctrl.sv
module fetch_mem_seq_ctrl
  import fetch_mem_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [OPC_W-1:0]     opcode,
  output seq_ctl_t             ctl
);

  seq_state_t st, nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_F_MAR;
    else        st <= nxt;
  end

  always_comb begin
    ctl = '0;
    nxt = st;
    unique case (st)
      S_F_MAR:  begin ctl.drive[DRV_PC] = 1'b1; ctl.mar_ld = 1'b1; nxt = S_F_RD; end
      S_F_RD:   begin ctl.mem_en = 1'b1; nxt = S_F_CAP; end
      S_F_CAP:  begin ctl.mdr_cap = 1'b1; nxt = S_F_IR; end
      S_F_IR:   begin
        ctl.drive[DRV_MDR] = 1'b1; ctl.ir_ld = 1'b1; ctl.pc_inc = 1'b1; nxt = S_DEC;
      end
      S_DEC: begin
        unique case (opcode)
          OP_ADD, OP_AND, OP_NOT:                 nxt = S_EXE;
          OP_LEA:                                 nxt = S_LEA;
          OP_LD, OP_LDR, OP_LDI, OP_ST, OP_STR, OP_STI: nxt = S_EA_MAR;
          default:                                nxt = S_ILL;
        endcase
      end
      S_EXE:    begin ctl.drive[DRV_ALU] = 1'b1; ctl.reg_ld = 1'b1; nxt = S_F_MAR; end
      S_LEA:    begin ctl.drive[DRV_EA] = 1'b1; ctl.reg_ld = 1'b1; nxt = S_F_MAR; end
      S_EA_MAR: begin
        ctl.drive[DRV_EA] = 1'b1; ctl.mar_ld = 1'b1;
        if (opcode == OP_LDI || opcode == OP_STI)      nxt = S_P_RD;
        else if (opcode == OP_ST || opcode == OP_STR)  nxt = S_S_DATA;
        else                                           nxt = S_D_RD;
      end
      S_P_RD:   begin ctl.mem_en = 1'b1; nxt = S_P_CAP; end
      S_P_CAP:  begin ctl.mdr_cap = 1'b1; nxt = S_P_MAR; end
      S_P_MAR:  begin
        ctl.drive[DRV_MDR] = 1'b1; ctl.mar_ld = 1'b1;
        nxt = (opcode == OP_STI) ? S_S_DATA : S_D_RD;
      end
      S_D_RD:   begin ctl.mem_en = 1'b1; nxt = S_D_CAP; end
      S_D_CAP:  begin ctl.mdr_cap = 1'b1; nxt = S_WB; end
      S_WB:     begin ctl.drive[DRV_MDR] = 1'b1; ctl.reg_ld = 1'b1; nxt = S_F_MAR; end
      S_S_DATA: begin ctl.drive[DRV_SRC] = 1'b1; ctl.mdr_ld_bus = 1'b1; nxt = S_S_WR; end
      S_S_WR:   begin ctl.mem_en = 1'b1; ctl.mem_we = 1'b1; nxt = S_F_MAR; end
      S_ILL:    begin ctl.illegal = 1'b1; nxt = S_F_MAR; end
      default:  nxt = S_F_MAR;
    endcase
  end

  // R10: one bus source per state
  assert_one_driver_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl.drive));

  // R4: a read enable is followed by the data capture
  assert_read_then_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.mem_en && !ctl.mem_we) |=> ctl.mdr_cap);

  // R6: a write is preceded by loading the data register from the bus
  assert_store_via_register_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.mem_we |-> $past(ctl.mdr_ld_bus));

  // R9: the flag lasts one cycle and is followed by a new fetch
  assert_illegal_refetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.illegal |=> (ctl.drive[DRV_PC] && ctl.mar_ld && !ctl.illegal));

endmodule

// File: rtl/fetch_mem_seq_regs.sv
module fetch_mem_seq_regs #(
  parameter int                WORD_W   = 16,
  parameter logic [WORD_W-1:0] RESET_PC = 'h3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mar_ld,
  input  logic              mdr_cap,
  input  logic              mdr_ld_bus,
  input  logic              ir_ld,
  input  logic              pc_inc,
  input  logic [WORD_W-1:0] bus,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] pc,
  output logic [WORD_W-1:0] mar,
  output logic [WORD_W-1:0] mdr,
  output logic [WORD_W-1:0] ir
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc  <= RESET_PC;
      mar <= '0;
      mdr <= '0;
      ir  <= '0;
    end else begin
      if (mar_ld)          mar <= bus;
      if (mdr_cap)         mdr <= mem_rdata;
      else if (mdr_ld_bus) mdr <= bus;
      if (ir_ld)           ir  <= bus;
      if (pc_inc)          pc  <= pc + 1'b1;
    end
  end

  // R2: loading the instruction advances the PC by one
  assert_fetch_advances_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ir_ld |=> (pc == $past(pc) + 1'b1));

endmodule

// File: rtl/fetch_mem_seq_bus.sv
module fetch_mem_seq_bus #(
  parameter int WORD_W = 16,
  parameter int NSRC   = 5
) (
  input  logic [NSRC-1:0]             sel,
  input  logic [NSRC-1:0][WORD_W-1:0] src,
  output logic [WORD_W-1:0]           bus
);

  logic [NSRC-1:0][WORD_W-1:0] gated;

  for (genvar g = 0; g < NSRC; g++) begin : g_gate
    assign gated[g] = sel[g] ? src[g] : '0;
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++) bus = bus | gated[i];
  end

endmodule

// File: rtl/fetch_mem_seq.sv
module fetch_mem_seq
  import fetch_mem_seq_pkg::*;
#(
  parameter int                WORD_W   = 16,
  parameter logic [WORD_W-1:0] RESET_PC = 'h3000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_en,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [WORD_W-1:0] ea_in,
  input  logic [WORD_W-1:0] alu_in,
  input  logic [WORD_W-1:0] src_in,
  output logic [WORD_W-1:0] pc,
  output logic [WORD_W-1:0] ir,
  output logic [WORD_W-1:0] bus_out,
  output logic              reg_ld,
  output logic              illegal
);

  localparam int OPC_LSB = WORD_W - OPC_W;

  seq_ctl_t                    ctl;
  logic [WORD_W-1:0]           mar, mdr;
  logic [NDRV-1:0][WORD_W-1:0] srcs;

  fetch_mem_seq_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (ir[WORD_W-1:OPC_LSB]),
    .ctl    (ctl)
  );

  fetch_mem_seq_regs #(.WORD_W(WORD_W), .RESET_PC(RESET_PC)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .mar_ld     (ctl.mar_ld),
    .mdr_cap    (ctl.mdr_cap),
    .mdr_ld_bus (ctl.mdr_ld_bus),
    .ir_ld      (ctl.ir_ld),
    .pc_inc     (ctl.pc_inc),
    .bus        (bus_out),
    .mem_rdata  (mem_rdata),
    .pc         (pc),
    .mar        (mar),
    .mdr        (mdr),
    .ir         (ir)
  );

  assign srcs[DRV_PC]  = pc;
  assign srcs[DRV_MDR] = mdr;
  assign srcs[DRV_ALU] = alu_in;
  assign srcs[DRV_EA]  = ea_in;
  assign srcs[DRV_SRC] = src_in;

  fetch_mem_seq_bus #(.WORD_W(WORD_W), .NSRC(NDRV)) u_bus (
    .sel (ctl.drive),
    .src (srcs),
    .bus (bus_out)
  );

  assign mem_en    = ctl.mem_en;
  assign mem_we    = ctl.mem_we;
  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign reg_ld    = ctl.reg_ld;
  assign illegal   = ctl.illegal;

endmodule

// File: tb/fetch_mem_seq_bench.sv
`timescale 1ns/1ps
module fetch_mem_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_en, mem_we, reg_ld, illegal;
  logic [15:0] mem_addr, mem_wdata, pc, ir, bus_out;
  logic [15:0] mem_rdata = '0;
  logic [15:0] ea_in, alu_in, src_in;

  always #2 clk = ~clk;  // 250 MHz

  fetch_mem_seq u_fetch_mem_seq (
    .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ea_in(ea_in), .alu_in(alu_in), .src_in(src_in), .pc(pc), .ir(ir),
    .bus_out(bus_out), .reg_ld(reg_ld), .illegal(illegal)
  );

  // memory with one cycle of read latency
  logic [15:0] mem [int];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[int'(mem_addr)] = mem_wdata;
      else        mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0000;
    end
  end

  // neighbour register file, ALU and address generator
  logic [15:0] rf [8];
  always @(posedge clk) if (rst_n && reg_ld) rf[ir[11:9]] <= bus_out;

  always_comb begin
    if (ir[15:12] == 4'h6 || ir[15:12] == 4'h7)
      ea_in = rf[ir[8:6]] + {{10{ir[5]}}, ir[5:0]};
    else
      ea_in = pc + {{7{ir[8]}}, ir[8:0]};
    case (ir[15:12])
      4'h1:    alu_in = rf[ir[8:6]] + (ir[5] ? {{11{ir[4]}}, ir[4:0]} : rf[ir[2:0]]);
      4'h5:    alu_in = rf[ir[8:6]] & (ir[5] ? {{11{ir[4]}}, ir[4:0]} : rf[ir[2:0]]);
      4'h9:    alu_in = ~rf[ir[8:6]];
      default: alu_in = '0;
    endcase
    src_in = rf[ir[11:9]];
  end

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // scoreboard: kind 0 = register write, 1 = memory write, 2 = unsupported flag
  int          kq[$];
  int          aq[$];
  logic [15:0] vq[$];
  string       rq[$];
  task automatic expect_item(input int k, input int a, input logic [15:0] v, input string r);
    kq.push_back(k); aq.push_back(a); vq.push_back(v); rq.push_back(r);
  endtask

  bit          done = 0;
  int          nreads = 0, nwrites = 0;
  int          snap_reads = 0, snap_writes = 0;
  logic [15:0] snap_pc = '0;

  task automatic observe(input int k, input int a, input logic [15:0] v);
    int ek; int ea; logic [15:0] ev; string er;
    if (kq.size() == 0) begin
      chk(1'b0, "R9", "unexpected event", 32'(k), 32'hFFFF);
      return;
    end
    ek = kq.pop_front(); ea = aq.pop_front(); ev = vq.pop_front(); er = rq.pop_front();
    chk(ek == k, er, "event kind", 32'(k), 32'(ek));
    chk(ea == a, er, "target", 32'(a), 32'(ea));
    chk(ev == v, er, "value", 32'(v), 32'(ev));
    if (k == 2) begin
      chk(pc == 16'h3005, "R9", "pc at flag", 32'(pc), 32'h3005);
      chk(bus_out == 16'h0, "R10", "idle bus", 32'(bus_out), 32'h0);
    end
    if (kq.size() == 0) begin
      done = 1; snap_reads = nreads; snap_writes = nwrites; snap_pc = pc;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (mem_en && !mem_we) nreads++;
      if (mem_en && mem_we) begin
        nwrites++;
        observe(1, int'(mem_addr), mem_wdata);
      end
      if (reg_ld)  observe(0, int'(ir[11:9]), bus_out);
      if (illegal) observe(2, 0, 16'h0);
    end
  end

  initial begin
    // program
    mem[32'h3000] = 16'hE204;  // address of 3005 into r1
    mem[32'h3001] = 16'h240E;  // r2 <- [3010]
    mem[32'h3002] = 16'h16BE;  // r3 <- r2 + -2
    mem[32'h3003] = 16'hA80D;  // r4 <- [[3011]]
    mem[32'h3004] = 16'hD000;  // unsupported
    mem[32'h3005] = 16'h764E;  // [r1+14] <- r3
    mem[32'h3006] = 16'hB80B;  // [[3012]] <- r4
    mem[32'h3007] = 16'h5B02;  // r5 <- r4 & r2
    mem[32'h3008] = 16'h9D7F;  // r6 <- ~r5
    mem[32'h3009] = 16'h3C0A;  // [3014] <- r6
    mem[32'h300A] = 16'h6E4E;  // r7 <- [r1+14]
    mem[32'h300B] = 16'h11C3;  // r0 <- r7 + r3
    mem[32'h300C] = 16'hE1F4;  // r0 <- 300D - 12
    mem[32'h3010] = 16'h1234;
    mem[32'h3011] = 16'h4000;
    mem[32'h3012] = 16'h5000;
    mem[32'h4000] = 16'hBEEF;
    for (int i = 0; i < 8; i++) rf[i] = '0;

    expect_item(0, 1, 16'h3005, "R8");
    expect_item(0, 2, 16'h1234, "R4");
    expect_item(0, 3, 16'h1232, "R3");
    expect_item(0, 4, 16'hBEEF, "R5");
    expect_item(2, 0, 16'h0000, "R9");
    expect_item(1, 32'h3013, 16'h1232, "R6");
    expect_item(1, 32'h5000, 16'hBEEF, "R7");
    expect_item(0, 5, 16'h1224, "R3");
    expect_item(0, 6, 16'hEDDB, "R3");
    expect_item(1, 32'h3014, 16'hEDDB, "R6");
    expect_item(0, 7, 16'h1232, "R4");
    expect_item(0, 0, 16'h2464, "R3 R10");
    expect_item(0, 0, 16'h3001, "R8");

    repeat (3) @(negedge clk);
    chk(pc == 16'h3000, "R1", "reset pc", 32'(pc), 32'h3000);
    chk(mem_en == 1'b0, "R1", "reset mem_en", 32'(mem_en), 32'h0);
    chk(reg_ld == 1'b0 && illegal == 1'b0, "R1", "reset strobes",
        32'({reg_ld, illegal}), 32'h0);
    rst_n = 1'b1;
    #1;
    chk(bus_out == 16'h3000, "R1", "pc on bus", 32'(bus_out), 32'h3000);
    @(negedge clk);
    chk(mem_en && !mem_we, "R1", "first access is read", 32'({mem_en, mem_we}), 32'h2);
    chk(mem_addr == 16'h3000, "R2", "fetch address", 32'(mem_addr), 32'h3000);

    for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
    if (!done) chk(1'b0, "R2", "watchdog expired", 32'(kq.size()), 32'h0);
    else begin
      // 13 fetches + 1 (LD) + 2 (LDI) + 1 (STI) + 1 (LDR); none for address-only
      chk(snap_reads == 18, "R5 R8", "read count", 32'(snap_reads), 32'd18);
      chk(snap_writes == 3, "R6 R7", "write count", 32'(snap_writes), 32'd3);
      chk(snap_pc == 16'h300D, "R2", "final pc", 32'(snap_pc), 32'h300D);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule